// File: doc/BRIEF.md
# Half-Bridge Sine PWM Sequencer

This block produces a sine-modulated pulse-width carrier for an inverter output stage built from two half-bridge legs. A carrier counter defines the switching period, and a step counter walks a half-wave sine duty table once per output half-cycle. In the default mode, one leg switches while the other stays low. At each half-cycle boundary the two legs swap roles, so the pair builds a full sine cycle from a table that holds only half a wave.

The carrier period is taken from an input at the end of every carrier cycle. An external phase or frequency loop can therefore nudge the period by a clock at a time and trim the output frequency without disturbing a pulse in progress. A second mode drives a single pin around a mid-scale offset: zero output is half the period in duty, positive half-cycles add the table value, and negative half-cycles subtract it. The block also exposes the step position and the half-cycle flag, plus a heartbeat that is high for one clock at the start of each full output cycle and can serve as a scope trigger.

Top module: `hb_sine_pwm`

## Requirements
- R1: While reset is asserted, and until the internal reset is released two clock edges after `rst_n` rises, both legs are low, `step_o` and `half_o` are 0, and `heartbeat` is high.
- R2: The carrier counter counts 0 to P-1, where P is the latched period. P is loaded from the clamped `period_i` only on the edge that ends a carrier (the wrap). A change to `period_i` therefore affects only the next carrier. After reset, P is `NOM_PER`.
- R3: `step_o` advances by one at each wrap and runs from 0 to STEPS-1. `half_o` toggles on the wrap where `step_o` rolls from STEPS-1 to 0.
- R4: In half-bridge mode (`mode_sel`=0), when `half_o`=0 the PWM appears on `leg_a` and `leg_b` is low. When `half_o`=1 the PWM appears on `leg_b` and `leg_a` is low. The two legs are never high together.
- R5: The table entry for step i is floor(AMP*16*i*(STEPS-i) / (5*STEPS*STEPS - 4*i*(STEPS-i))). This gives 0 at i=0 and AMP at i=STEPS/2. In half-bridge mode the compare value is the entry for the step and half-cycle that begin at the wrap.
- R6: The compare value and the mode are latched only at a wrap. Changing `mode_sel` mid-carrier has no effect until the next wrap. The compare value is 0 out of reset.
- R7: In single-pin mode (`mode_sel`=1), the compare value is floor(P/2) + (entry>>1) when `half_o`=0 and floor(P/2) - (entry>>1) when `half_o`=1. P is the newly latched period, and a negative result is clamped to 0. The PWM appears on `leg_a`, and `leg_b` stays low.
- R8: The PWM is high while the carrier count is below the compare value. A compare of 0 keeps it low for the whole carrier, and a compare of at least P keeps it high for the whole carrier.
- R9: A `period_i` value below 2 is latched as 2.
- R10: `heartbeat` is high exactly when the carrier count is 0, `step_o` is 0 and `half_o` is 0, which is one clock per full output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| period_i | input | PER_W | Carrier period in clocks, taken at each wrap |
| mode_sel | input | 1 | 0 = two-leg half-bridge, 1 = single-pin offset |
| leg_a | output | 1 | PWM drive for leg A (the single pin in mode 1) |
| leg_b | output | 1 | PWM drive for leg B |
| step_o | output | STEP_W | Current table step |
| half_o | output | 1 | Current half-cycle flag |
| heartbeat | output | 1 | One-clock marker at the start of each output cycle |

## Verification
The bench builds the block with PER_W=8, NOM_PER=16, STEPS=8 and AMP=12. With these values a full output cycle is 256 clocks, so many cycles, both half-cycle swaps and every table entry are covered in a short run. The table peak of 12 is above a trimmed period of 10, which makes the saturated-high case reachable. With a period of 6, the single-pin negative half-cycle drops below zero, which exercises the clamp to 0. Periods of 0 and 1 exercise the minimum-period clamp, and period and mode changes in mid-carrier show that only wraps pick them up.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  // Half-wave sine approximation over i in [0, n]: rational form, peak amp at n/2.
  function automatic int unsigned sine_pt(int unsigned i, int unsigned n, int unsigned amp);
    int unsigned prod;
    prod = i * (n - i);
    return (amp * 16 * prod) / (5 * n * n - 4 * prod);
  endfunction
endpackage

// File: rtl/hbs_carrier.sv
module hbs_carrier #(
  parameter int PER_W   = 12,
  parameter int NOM_PER = 800,
  parameter int MIN_PER = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  output logic [PER_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic [PER_W-1:0] per_nx_o
);
  localparam logic [PER_W-1:0] NOM = PER_W'(NOM_PER);
  localparam logic [PER_W-1:0] MIN = PER_W'(MIN_PER);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q;
  logic             wrap;

  always_comb begin
    wrap     = (cnt_q == per_q - PER_W'(1));
    per_nx_o = (period_i < MIN) ? MIN : period_i;
    cnt_d    = wrap ? '0 : cnt_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    per_q <= NOM;
    else if (wrap) per_q <= per_nx_o;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap;

  p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < per_q);
  p_per_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    per_q >= MIN);
  p_per_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(per_q));
endmodule

// File: rtl/hbs_sequencer.sv
module hbs_sequencer #(
  parameter int STEPS  = 200,
  parameter int STEP_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  output logic [STEP_W-1:0] step_o,
  output logic              half_o,
  output logic [STEP_W-1:0] step_nx_o,
  output logic              half_nx_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  logic [STEP_W-1:0] step_q;
  logic              half_q;
  logic              roll;

  always_comb begin
    roll      = (step_q == LAST);
    step_nx_o = roll ? '0 : step_q + STEP_W'(1);
    half_nx_o = roll ? ~half_q : half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      half_q <= 1'b0;
    end else if (adv_i) begin
      step_q <= step_nx_o;
      half_q <= half_nx_o;
    end
  end

  assign step_o = step_q;
  assign half_o = half_q;

  p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST);
  p_half_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && step_q == LAST) |=> (half_q != $past(half_q)) && (step_q == '0));
  p_half_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != LAST) |=> $stable(half_q));
endmodule

// File: rtl/hbs_duty.sv
module hbs_duty #(
  parameter int PER_W  = 12,
  parameter int STEPS  = 200,
  parameter int AMP    = 760,
  parameter int STEP_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              mode_i,
  input  logic [STEP_W-1:0] step_nx_i,
  input  logic              half_nx_i,
  input  logic [PER_W-1:0]  per_nx_i,
  output logic [PER_W-1:0]  cmp_o,
  output logic              mode_o
);
  localparam int SW = PER_W + 2;

  logic [PER_W-1:0] rom [STEPS];

  for (genvar g = 0; g < STEPS; g++) begin : g_rom
    assign rom[g] = PER_W'(hbs_pkg::sine_pt(g, STEPS, AMP));
  end

  logic [PER_W-1:0]  entry;
  logic signed [SW-1:0] mid, swing, sum;
  logic [PER_W-1:0]  cmp_d;
  logic [PER_W-1:0]  cmp_q;
  logic              mode_q;

  always_comb begin
    entry = rom[step_nx_i];
    mid   = SW'(per_nx_i >> 1);
    swing = SW'(entry >> 1);
    sum   = half_nx_i ? (mid - swing) : (mid + swing);
    if (!mode_i)         cmp_d = entry;
    else if (sum < 0)    cmp_d = '0;
    else                 cmp_d = PER_W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mode_q <= 1'b0;
    end else if (load_i) begin
      cmp_q  <= cmp_d;
      mode_q <= mode_i;
    end
  end

  assign cmp_o  = cmp_q;
  assign mode_o = mode_q;

  p_cmp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(cmp_q) && $stable(mode_q));
  p_entry_peak_r5: assert property (@(posedge clk) disable iff (!rst_n)
    entry <= PER_W'(AMP));
endmodule

// File: rtl/hb_sine_pwm.sv
module hb_sine_pwm #(
  parameter int PER_W   = 12,
  parameter int NOM_PER = 800,
  parameter int STEPS   = 200,
  parameter int AMP     = 760,
  parameter int STEP_W  = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PER_W-1:0]  period_i,
  input  logic              mode_sel,
  output logic              leg_a,
  output logic              leg_b,
  output logic [STEP_W-1:0] step_o,
  output logic              half_o,
  output logic              heartbeat
);
  logic rs1_q, rs2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  logic srst_n;
  assign srst_n = rs2_q;

  logic [PER_W-1:0]  cnt, per_nx, cmp;
  logic              wrap, mode_q, half_nx;
  logic [STEP_W-1:0] step_nx;

  hbs_carrier #(.PER_W(PER_W), .NOM_PER(NOM_PER), .MIN_PER(2)) u_car (
    .clk(clk), .rst_n(srst_n), .period_i(period_i),
    .cnt_o(cnt), .wrap_o(wrap), .per_nx_o(per_nx));

  hbs_sequencer #(.STEPS(STEPS), .STEP_W(STEP_W)) u_seq (
    .clk(clk), .rst_n(srst_n), .adv_i(wrap),
    .step_o(step_o), .half_o(half_o), .step_nx_o(step_nx), .half_nx_o(half_nx));

  hbs_duty #(.PER_W(PER_W), .STEPS(STEPS), .AMP(AMP), .STEP_W(STEP_W)) u_duty (
    .clk(clk), .rst_n(srst_n), .load_i(wrap), .mode_i(mode_sel),
    .step_nx_i(step_nx), .half_nx_i(half_nx), .per_nx_i(per_nx),
    .cmp_o(cmp), .mode_o(mode_q));

  logic pwm;
  always_comb begin
    pwm       = (cnt < cmp);
    leg_a     = mode_q ? pwm : (pwm & ~half_o);
    leg_b     = mode_q ? 1'b0 : (pwm & half_o);
    heartbeat = (cnt == '0) && (step_o == '0) && !half_o;
  end

  p_legs_excl_r4: assert property (@(posedge clk) disable iff (!srst_n)
    !(leg_a && leg_b));
  p_single_b_low_r7: assert property (@(posedge clk) disable iff (!srst_n)
    mode_q |-> !leg_b);
  p_hb_once_r10: assert property (@(posedge clk) disable iff (!srst_n)
    heartbeat |=> !heartbeat);
endmodule

// File: tb/sim_hb_sine_pwm.sv
module sim_hb_sine_pwm;
  localparam int PER_W = 8, NOM_PER = 16, STEPS = 8, AMP = 12;
  localparam int STEP_W = $clog2(STEPS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PER_W-1:0] period_i = PER_W'(NOM_PER);
  logic mode_sel = 1'b0;
  logic leg_a, leg_b, half_o, heartbeat;
  logic [STEP_W-1:0] step_o;

  always #2.5 clk = ~clk;

  hb_sine_pwm #(.PER_W(PER_W), .NOM_PER(NOM_PER), .STEPS(STEPS), .AMP(AMP)) u0 (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .mode_sel(mode_sel),
    .leg_a(leg_a), .leg_b(leg_b), .step_o(step_o), .half_o(half_o),
    .heartbeat(heartbeat));

  int checks = 0, fails = 0;
  bit running = 0;

  function automatic int entry_of(int i);
    int p;
    p = i * (STEPS - i);
    return (AMP * 16 * p) / (5 * STEPS * STEPS - 4 * p);
  endfunction

  // behavioural reference model
  int m_cnt, m_per, m_step, m_half, m_cmp, m_mode, rs;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs = 0; m_cnt = 0; m_per = NOM_PER; m_step = 0; m_half = 0; m_cmp = 0; m_mode = 0;
    end else begin
      if (rs == 2) begin
        if (m_cnt == m_per - 1) begin
          int np, e, c;
          np = (int'(period_i) < 2) ? 2 : int'(period_i);
          m_cnt = 0;
          m_step = m_step + 1;
          if (m_step == STEPS) begin m_step = 0; m_half = 1 - m_half; end
          e = entry_of(m_step);
          if (mode_sel == 1'b0) c = e;
          else begin
            c = (m_half == 0) ? (np / 2 + e / 2) : (np / 2 - e / 2);
            if (c < 0) c = 0;
          end
          m_cmp = c; m_per = np; m_mode = int'(mode_sel);
        end else m_cnt = m_cnt + 1;
      end
      if (rs < 2) rs = rs + 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      int pwm, ea, eb;
      pwm = (m_cnt < m_cmp) ? 1 : 0;
      ea = m_mode ? pwm : (m_half == 0 ? pwm : 0);
      eb = m_mode ? 0 : (m_half == 1 ? pwm : 0);
      chk("R3 R2 R9 step", int'(step_o), m_step);
      chk("R3 half", int'(half_o), m_half);
      chk(m_mode ? "R7 R8 R6 leg_a" : "R4 R5 R8 R6 leg_a", int'(leg_a), ea);
      chk(m_mode ? "R7 leg_b" : "R4 R5 R8 leg_b", int'(leg_b), eb);
      chk("R10 heartbeat", int'(heartbeat), (m_cnt == 0 && m_step == 0 && m_half == 0) ? 1 : 0);
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(4);
    // R1 reset state
    chk("R1 leg_a", int'(leg_a), 0);
    chk("R1 leg_b", int'(leg_b), 0);
    chk("R1 step", int'(step_o), 0);
    chk("R1 half", int'(half_o), 0);
    chk("R1 heartbeat", int'(heartbeat), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 held after release", int'(step_o) + int'(leg_a), 0);
    running = 1;
    // half-bridge mode, nominal period
    run(600);
    // period trimming: change mid-carrier, only wraps pick it up (R2)
    for (int k = 0; k < 70; k++) begin
      period_i = PER_W'((k % 3 == 0) ? 15 : (k % 3 == 1) ? 17 : 16);
      run(9);
    end
    // period below peak entry: saturated high (R8)
    period_i = 8'd10;
    run(300);
    // single-pin mode, mode changed mid-carrier (R6, R7)
    period_i = 8'd16;
    run(5);
    mode_sel = 1'b1;
    run(600);
    period_i = 8'd11;
    run(300);
    // negative clamp in single-pin mode (R7)
    period_i = 8'd6;
    run(200);
    // minimum period clamp (R9)
    period_i = 8'd0;
    run(100);
    period_i = 8'd1;
    mode_sel = 1'b0;
    run(100);
    period_i = 8'd16;
    run(300);
    running = 0;
    summary();
    $finish;
  end
endmodule